// File: doc/BRIEF.md
# I2C Buffered Register Slave

This block is an I2C target that presents a 32-byte memory to an external bus master. The master first writes a one-byte index to select a location, then either streams bytes into the memory or reads them back; the index moves forward by one after every byte and wraps at the end of the memory. All bus traffic is handled in hardware: the slave never stretches SCL, and no local processor action is needed per byte.

The same memory is open to the local side through a synchronous port. The local side keeps the contents current, and the slave returns whatever the memory holds. SCL and SDA are sampled by the block's own clock, which must run well above the bus bit rate. SDA is open drain: the block pulls the line low when `sda_oe` is 1. The 7-bit bus address is a parameter (default 0x2A).

Top module: `i2cbuf_slave`

## Requirements
- R1: After a synchronous active-low reset, `sda_oe` is 0, `loc_rdata` is 0, every memory byte is 0 and the byte index is 0.
- R2: A byte after Start whose upper 7 bits (MSB first) equal the slave address is acknowledged: SDA is held low through the ninth SCL pulse. This holds for both R/W values (bit 0: 0 = write, 1 = read).
- R3: A non-matching address is not acknowledged, and every later byte is ignored (no ACK, no memory change, index unchanged) until the next Start.
- R4: In a write transfer, the first data byte loads the index from its low 5 bits. Each later byte is stored at the index, and the index then advances by one. Every data byte is acknowledged.
- R5: A read transfer returns bytes MSB first, starting at the current index and advancing by one per byte sent. After a master NACK the slave releases SDA and stays silent until Stop or Start.
- R6: The index wraps from 31 to 0 for both reads and writes.
- R7: A Repeated Start keeps the index, so a write that only sets the index, followed by a read, reads from that index.
- R8: The local port writes `loc_wdata` at `loc_addr` on a clock edge with `loc_en` and `loc_we` high. A read (`loc_en` high, `loc_we` low) returns the byte in `loc_rdata` one cycle later. Both directions see bytes written by the other side.
- R9: When a local write and a bus byte commit target the same location in the same cycle, the local data is kept. A bus commit to a different location in that cycle still lands.
- R10: The slave changes its SDA drive only while SCL is low, and it has no SCL driver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| loc_en | input | 1 | Local access strobe |
| loc_we | input | 1 | Local access is a write |
| loc_addr | input | 5 | Local byte location |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data, one cycle after the request |

## Verification
Assertions check on every cycle that the SDA drive moves only while the synchronized SCL is low, and that the slave is silent when idle or ignoring. They also check that SDA is held low through an address ACK, that SDA is released for the master's acknowledge slot, that a Start leaves the index untouched, and that the same-location write conflict resolves in favour of the local side. The index arithmetic can only be shown by the bench's transfers: loading from the first byte, modulo-32 wrap across a multi-byte burst, and continuation across Repeated Start and a later transfer. The same holds for the ignore behaviour after a wrong address, which shows up only in the memory contents and in later reads.

// File: rtl/i2cbuf_pkg.sv
// Shared types for the buffered I2C slave.
// Assumes the bus byte width is fixed at eight bits.
package i2cbuf_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } bus_state_e;

    // Synchronized bus levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;
endpackage

// File: rtl/i2cbuf_busmon.sv
// Bus monitor: brings SCL/SDA into the clock domain through a shift
// chain and derives edges and Start/Stop conditions.
// Assumes clk runs many times faster than SCL.
module i2cbuf_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output i2cbuf_pkg::bus_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh, sda_sh;
    logic         scl_q, sda_q;
    logic         scl_s, sda_s;

    // Synchronizer chains plus one history stage; the bus idles high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
            scl_q  <= scl_sh[TOP];
            sda_q  <= sda_sh[TOP];
        end
    end

    assign scl_s = scl_sh[TOP];
    assign sda_s = sda_sh[TOP];

    // Event decode: SDA moving while SCL stays high marks Start or Stop
    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cbuf_ram.sv
// Shared byte memory with a local synchronous port and a bus port.
// The bus side writes once per byte and reads asynchronously.
// Assumes a local write wins when both ports write one location in one cycle.
module i2cbuf_ram #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loc_en,
    input  logic          loc_we,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] loc_rdata,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_waddr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [AW-1:0] bus_raddr,
    output logic [DW-1:0] bus_rdata
);
    logic          loc_wr;
    logic [DW-1:0] words [DEPTH];

    assign loc_wr = loc_en & loc_we;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] word_q;
        // One storage word; the local port has priority over the bus
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (loc_wr && loc_addr == AW'(g))
                word_q <= loc_wdata;
            else if (bus_we && bus_waddr == AW'(g))
                word_q <= bus_wdata;
        end
        assign words[g] = word_q;
    end

    // Registered local read, one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n)
            loc_rdata <= '0;
        else if (loc_en && !loc_we)
            loc_rdata <= words[loc_addr];
    end

    assign bus_rdata = words[bus_raddr];

    // R9: on a same-location clash the stored byte is the local one
    p_local_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_wr && bus_we && loc_addr == bus_waddr)
        |=> words[$past(loc_addr)] == $past(loc_wdata));

    // R4/R9: a bus commit not hit by a local write lands
    p_bus_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !(loc_wr && loc_addr == bus_waddr))
        |=> words[$past(bus_waddr)] == $past(bus_wdata));
endmodule

// File: rtl/i2cbuf_proto.sv
// Bus protocol engine: address match, ACK, byte shifting and the
// auto-advancing byte index. Never touches SCL.
// Assumes events from i2cbuf_busmon and an asynchronous-read memory.
module i2cbuf_proto #(
    parameter logic [6:0] SLV_ADDR = 7'h2A,
    parameter int         AW       = 5,
    parameter int         DW       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  i2cbuf_pkg::bus_ev_t ev,
    input  logic [DW-1:0]       bus_rdata,
    output logic                sda_oe,
    output logic                bus_we,
    output logic [AW-1:0]       bus_waddr,
    output logic [DW-1:0]       bus_wdata,
    output logic [AW-1:0]       bus_raddr
);
    import i2cbuf_pkg::*;

    localparam logic [3:0] CNT_BYTE = 4'(DW);
    localparam logic [3:0] CNT_ACK  = 4'(DW + 1);
    localparam logic [3:0] CNT_LAST = 4'(DW - 1);

    bus_state_e    state;
    logic [3:0]    bitcnt;
    logic [DW-1:0] shreg;
    logic [AW-1:0] ptr;
    logic          first_byte;
    logic          rw;

    // Bus-side memory access: commit strobe on the fall after bit eight
    always_comb begin
        bus_we    = (state == ST_WRITE) && ev.scl_fall && (bitcnt == CNT_BYTE)
                    && !first_byte && !ev.start && !ev.stop;
        bus_waddr = ptr;
        bus_wdata = shreg;
        bus_raddr = ptr;
    end

    // Main sequencer: Start/Stop first, then per-state bit handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            ptr        <= '0;
            first_byte <= 1'b1;
            rw         <= 1'b0;
            sda_oe     <= 1'b0;
        end else if (ev.start) begin
            state      <= ST_ADDR;
            bitcnt     <= '0;
            first_byte <= 1'b1;
            sda_oe     <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WRITE: begin
                    if (ev.scl_rise && bitcnt < CNT_BYTE) begin
                        shreg  <= {shreg[DW-2:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == CNT_BYTE) begin
                        if (state == ST_ADDR) begin
                            if (shreg[DW-1:1] == SLV_ADDR) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                bitcnt <= CNT_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else begin
                            sda_oe <= 1'b1;
                            bitcnt <= CNT_ACK;
                            if (first_byte) begin
                                ptr        <= shreg[AW-1:0];
                                first_byte <= 1'b0;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                        end
                    end else if (ev.scl_fall && bitcnt == CNT_ACK) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (rw) begin
                                state  <= ST_READ;
                                shreg  <= bus_rdata;
                                sda_oe <= ~bus_rdata[DW-1];
                                ptr    <= ptr + 1'b1;
                            end else begin
                                state <= ST_WRITE;
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (ev.scl_fall) begin
                        if (bitcnt < CNT_LAST) begin
                            bitcnt <= bitcnt + 4'd1;
                            sda_oe <= ~shreg[DW-2];
                            shreg  <= {shreg[DW-2:0], 1'b0};
                        end else if (bitcnt == CNT_LAST) begin
                            bitcnt <= CNT_BYTE;
                            sda_oe <= 1'b0;
                        end else if (bitcnt == CNT_ACK) begin
                            shreg  <= bus_rdata;
                            sda_oe <= ~bus_rdata[DW-1];
                            ptr    <= ptr + 1'b1;
                            bitcnt <= '0;
                        end
                    end else if (ev.scl_rise && bitcnt == CNT_BYTE) begin
                        if (ev.sda) state  <= ST_IGNORE;
                        else        bitcnt <= CNT_ACK;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: the SDA drive moves only while the synchronized SCL is low
    p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !ev.scl);

    // R1: no drive while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R3: no drive while ignoring traffic
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_oe);

    // R2: SDA is held low throughout the address ACK slot
    p_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && bitcnt == CNT_ACK) |-> sda_oe);

    // R5: SDA is released for the master's acknowledge slot
    p_release_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && bitcnt == CNT_BYTE) |-> !sda_oe);

    // R7: a Start leaves the byte index untouched
    p_restart_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> ptr == $past(ptr));
endmodule

// File: rtl/i2cbuf_slave.sv
// Top of the buffered I2C slave: bus monitor, protocol engine and
// shared 32-byte memory with a local synchronous port.
// Assumes an open-drain SDA pad driven low by sda_oe; SCL is input only.
module i2cbuf_slave #(
    parameter logic [6:0] SLV_ADDR    = 7'h2A,
    parameter int         DEPTH       = 32,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       loc_en,
    input  logic       loc_we,
    input  logic [4:0] loc_addr,
    input  logic [7:0] loc_wdata,
    output logic [7:0] loc_rdata
);
    localparam int DW = i2cbuf_pkg::BYTE_W;
    localparam int AW = $clog2(DEPTH);

    i2cbuf_pkg::bus_ev_t ev;
    logic                bus_we;
    logic [AW-1:0]       bus_waddr, bus_raddr;
    logic [DW-1:0]       bus_wdata, bus_rdata;

    i2cbuf_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cbuf_proto #(.SLV_ADDR(SLV_ADDR), .AW(AW), .DW(DW)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .bus_rdata (bus_rdata),
        .sda_oe    (sda_oe),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr)
    );

    i2cbuf_ram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_en    (loc_en),
        .loc_we    (loc_we),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata),
        .bus_we    (bus_we),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_raddr (bus_raddr),
        .bus_rdata (bus_rdata)
    );
endmodule

// File: tb/i2cbuf_slave_bench.sv
module i2cbuf_slave_bench;
    localparam logic [6:0] ADDR = 7'h2A;
    localparam int HP = 10;  // SCL half period in clk cycles
    localparam int Q  = 3;   // data change delay after SCL fall

    // Table: {index byte, data byte}; location = index byte & 31
    localparam logic [15:0] VEC [0:7] = '{
        16'h02A1, 16'h035C, 16'hE40F, 16'h07FF,
        16'h4896, 16'h093E, 16'h2AC7, 16'h0B81
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_bus;
    logic       sda_oe;
    logic       loc_en = 1'b0, loc_we = 1'b0;
    logic [4:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;

    int  n_chk = 0, n_fail = 0, r10_viol = 0;
    bit  done = 1'b0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_mem [32];

    assign sda_bus = ~(m_low | sda_oe);

    always #10 clk = ~clk;  // 50 MHz

    i2cbuf_slave #(.SLV_ADDR(ADDR)) u_i2cbuf_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .loc_en(loc_en), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

    // R10 monitor: slave SDA drive must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != prev_oe && scl) r10_viol++;
        prev_oe = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        tick(Q); m_low = 1'b0; tick(HP - Q); scl = 1'b1; tick(HP);
        m_low = 1'b1; tick(HP); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_low = 1'b1; tick(HP - Q); scl = 1'b1; tick(HP);
        m_low = 1'b0; tick(HP);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_low = ~b[i]; tick(HP - Q); scl = 1'b1; tick(HP); scl = 1'b0;
        end
        tick(Q); m_low = 1'b0; tick(HP - Q); scl = 1'b1; tick(HP / 2);
        ack = ~sda_bus; tick(HP - HP / 2); scl = 1'b0;
    endtask

    task automatic get_byte(input logic m_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_low = 1'b0; tick(HP - Q); scl = 1'b1; tick(HP / 2);
            b[i] = sda_bus; tick(HP - HP / 2); scl = 1'b0;
        end
        tick(Q); m_low = m_ack; tick(HP - Q); scl = 1'b1; tick(HP); scl = 1'b0;
        tick(Q); m_low = 1'b0;
    endtask

    task automatic loc_write(input logic [4:0] a, input logic [7:0] d);
        loc_en = 1'b1; loc_we = 1'b1; loc_addr = a; loc_wdata = d;
        tick(1);
        loc_en = 1'b0; loc_we = 1'b0;
        exp_mem[a] = d;
    endtask

    task automatic loc_read(input logic [4:0] a, output logic [7:0] d);
        loc_en = 1'b1; loc_we = 1'b0; loc_addr = a;
        tick(1);
        loc_en = 1'b0;
        d = loc_rdata;
    endtask

    // Write transfer: index byte then n data bytes; model tracks memory
    task automatic wr_xfer(input logic [7:0] pb, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n, input string req);
        logic ack;
        logic [7:0] dd [3];
        logic [4:0] p;
        dd[0] = d0; dd[1] = d1; dd[2] = d2;
        p = pb[4:0];
        bus_start();
        put_byte({ADDR, 1'b0}, ack); chk({req, " R2 write address ACK"}, ack, 1);
        put_byte(pb, ack);           chk({req, " R4 index byte ACK"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            put_byte(dd[k], ack);    chk({req, " R4 data byte ACK"}, ack, 1);
            exp_mem[p] = dd[k];
            p = p + 5'd1;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        logic ack;
        logic [7:0] rd;
        for (int i = 0; i < 32; i++) exp_mem[i] = 8'h00;
        tick(5);
        // R1: reset state
        chk("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 loc_rdata after reset", loc_rdata, 0);
        loc_read(5'd5, rd); chk("R1 memory cleared", rd, 0);

        // R1/R5/R8: index starts at 0; local writes seen by bus reads
        loc_write(5'd0, 8'h3C);
        loc_write(5'd1, 8'h7E);
        bus_start();
        put_byte({ADDR, 1'b1}, ack); chk("R2 read address ACK", ack, 1);
        get_byte(1'b1, rd); chk("R1 R5 R8 first read from index 0", rd, 8'h3C);
        get_byte(1'b0, rd); chk("R5 second read advances", rd, 8'h7E);
        chk("R5 SDA released after NACK", sda_oe, 0);
        bus_stop();

        // R4/R8: table of single-byte writes, checked from the local side
        for (int v = 0; v < 8; v++) begin
            logic [4:0] a;
            a = VEC[v][12:8];
            wr_xfer(VEC[v][15:8], VEC[v][7:0], 8'h00, 8'h00, 1, "table");
            bus_stop();
            loc_read(a, rd);
            chk("R4 R8 table byte at index mod 32", rd, exp_mem[a]);
        end

        // R6: burst write across the top of the memory
        wr_xfer(8'd30, 8'h11, 8'h22, 8'h33, 3, "wrap");
        bus_stop();
        loc_read(5'd30, rd); chk("R4 burst byte at 30", rd, 8'h11);
        loc_read(5'd31, rd); chk("R4 burst byte at 31", rd, 8'h22);
        loc_read(5'd0,  rd); chk("R6 write wraps to 0", rd, 8'h33);

        // R7: set index, Repeated Start, read across the wrap
        wr_xfer(8'd30, 8'h00, 8'h00, 8'h00, 0, "restart");
        bus_start();
        put_byte({ADDR, 1'b1}, ack); chk("R7 read address ACK after restart", ack, 1);
        get_byte(1'b1, rd); chk("R7 read from kept index 30", rd, 8'h11);
        get_byte(1'b1, rd); chk("R5 read index 31", rd, 8'h22);
        get_byte(1'b0, rd); chk("R6 read wraps to 0", rd, 8'h33);
        bus_stop();

        // R5: a new read transfer continues from the advanced index (1)
        bus_start();
        put_byte({ADDR, 1'b1}, ack);
        get_byte(1'b0, rd); chk("R5 next transfer continues at index 1", rd, 8'h7E);
        bus_stop();

        // R3: wrong address, following bytes ignored
        bus_start();
        put_byte({ADDR ^ 7'h01, 1'b0}, ack); chk("R3 wrong address NACK", ack, 0);
        put_byte(8'h05, ack); chk("R3 ignored index byte NACK", ack, 0);
        put_byte(8'h99, ack); chk("R3 ignored data byte NACK", ack, 0);
        bus_stop();
        loc_read(5'd5, rd); chk("R3 memory unchanged", rd, exp_mem[5]);
        bus_start();
        put_byte({ADDR, 1'b1}, ack); chk("R3 next Start answered", ack, 1);
        get_byte(1'b0, rd); chk("R3 index unchanged (2)", rd, exp_mem[2]);
        bus_stop();

        // R9: local write held on the same location during a bus commit
        loc_en = 1'b1; loc_we = 1'b1; loc_addr = 5'd12; loc_wdata = 8'hC3;
        wr_xfer(8'd12, 8'h55, 8'h00, 8'h00, 1, "clash");
        bus_stop();
        loc_en = 1'b0; loc_we = 1'b0;
        exp_mem[12] = 8'hC3;
        loc_read(5'd12, rd); chk("R9 local write wins same location", rd, 8'hC3);

        // R9: local write elsewhere does not block the bus commit
        loc_en = 1'b1; loc_we = 1'b1; loc_addr = 5'd13; loc_wdata = 8'h6D;
        wr_xfer(8'd12, 8'h5A, 8'h00, 8'h00, 1, "side");
        bus_stop();
        loc_en = 1'b0; loc_we = 1'b0;
        loc_read(5'd12, rd); chk("R9 bus byte lands beside local write", rd, 8'h5A);
        loc_read(5'd13, rd); chk("R9 R8 local byte stored", rd, 8'h6D);

        chk("R10 SDA drive moved only with SCL low", r10_viol, 0);
        done = 1'b1;
        finish_run();
    end
endmodule